// File: doc/BRIEF.md
# Packet CRC Appender with Test Corruption

This block sits on the transmit side of a single serial lane. Packets arrive as a stream of words with start and end markers. The block computes a 32-bit CRC over each packet and inserts it as extra words straight after the packet's last word. The whole path uses valid/ready handshakes. While the CRC words go out, the block holds its input ready low, so no word is dropped.

For testing a receiver's checker, a force control can corrupt payload words. On any accepted in-packet word where the control is high, that word leaves the block XORed with a programmable pattern. The CRC is still formed from the clean word, so a correct receiver reports a mismatch. The pattern is held in a register that takes new values only between packets. A sticky flag reports that the most recent packet was corrupted. Packets shorter than a minimum length get no CRC; they are marked with a short-packet flag instead.

Top module: `pkt_crc_tx`

## Requirements
- R1: In the cycle after a cycle with `rst` high, `out_valid` is 0, `in_ready` is 1 and `err_injected` is 0.
- R2: A packet of at least `MIN_WORDS` words comes out as its words in order, with `out_sop` on the first. These are followed by 32/`DATA_W` CRC words, most significant part first. `out_is_crc` is 1 only on those words, and `out_eop` is 1 only on the final CRC word.
- R3: The CRC uses polynomial 0x04C11DB7 and is preset to all ones at every accepted start word. Each word is fed most significant bit first, and the appended value is the bitwise inverse of the register.
- R4: An accepted word that starts a packet or lies inside one, with `force_err` high, leaves as the word XORed with the held force pattern. The CRC is still computed from the uncorrupted word.
- R5: `force_err` has no effect in cycles with no accepted in-packet word, whether the block is idle or a packet has a gap.
- R6: The force pattern register loads `force_val` only in cycles with no packet in progress and no start word accepted. A change of `force_val` during a packet does not affect that packet.
- R7: `err_injected` is set by any corrupted word. It keeps its value until the next accepted start word, which clears it unless that word itself is corrupted.
- R8: `in_ready` is 0 while CRC words remain to be sent, including the cycle right after the end word is accepted. No input or output word is lost.
- R9: A packet with fewer than `MIN_WORDS` words gets no CRC words. Its last word carries `out_eop` = 1 and `out_short` = 1, with `out_is_crc` = 0.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output holds its value into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | Word starts a packet |
| in_eop | input | 1 | Word ends a packet |
| force_err | input | 1 | Corrupt this cycle's in-packet word |
| force_val | input | DATA_W | Corruption pattern, sampled between packets |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_is_crc | output | 1 | Word carries part of the CRC |
| out_short | output | 1 | Packet was too short for a CRC |
| err_injected | output | 1 | Sticky: the current or last packet was corrupted |

## Verification
Four properties are checked on every cycle: input ready stays low while CRC words remain, outputs hold steady under back-pressure, the short-packet marking is only ever paired with an end word, and the sticky flag changes only on an accepted input word. The CRC value, the placement of corruption, and the freezing of the pattern during a packet depend on whole packets. These are shown only by the bench's scenarios, which compare every output word with a reference CRC and a model of the corruption.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

  typedef enum logic {ST_DATA, ST_APPEND} tx_state_t;
endpackage

// File: rtl/pkt_crc_engine.sv
// Running CRC register: preset on a start word, advanced by one word per update.
module pkt_crc_engine #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              update,
  input  logic [DATA_W-1:0] data,
  output logic [31:0]       crc_next
);
  import pkt_crc_pkg::*;

  logic [31:0] crc_q;
  logic [31:0] work;
  logic        fb;

  // R3: bit-serial division, most significant bit first
  always_comb begin
    work = start ? CRC_INIT : crc_q;
    fb   = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb   = work[31] ^ data[i];
      work = {work[30:0], 1'b0};
      if (fb) work = work ^ CRC_POLY;
    end
    crc_next = work;
  end

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= CRC_INIT;
    else if (update) crc_q <= crc_next;
  end
endmodule

// File: rtl/pkt_len_gate.sv
// Counts packet words up to the minimum and flags packets that end short.
module pkt_len_gate #(
  parameter int MIN_WORDS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic update,
  output logic is_short
);
  localparam int CNT_W = $clog2(MIN_WORDS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_next;

  always_comb begin
    if (start)                               cnt_next = CNT_W'(1);
    else if (cnt_q >= CNT_W'(MIN_WORDS))     cnt_next = cnt_q;
    else                                     cnt_next = cnt_q + CNT_W'(1);
    is_short = (cnt_next < CNT_W'(MIN_WORDS));
  end

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (update) cnt_q <= cnt_next;
  end
endmodule

// File: rtl/pkt_err_inject.sv
// Held corruption pattern, per-word XOR and sticky corruption record.
module pkt_err_inject #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] force_val,
  input  logic              hit,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              sticky
);
  logic [DATA_W-1:0] pat_q;

  assign data_out = hit ? (data_in ^ pat_q) : data_in;   // R4

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      sticky <= 1'b0;
    end else begin
      if (load_en) pat_q <= force_val;                    // R6
      if (start)   sticky <= hit;                         // R7
      else if (hit) sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_crc_tx.sv
module pkt_crc_tx #(
  parameter int DATA_W    = 16,
  parameter int MIN_WORDS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              force_err,
  input  logic [DATA_W-1:0] force_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_is_crc,
  output logic              out_short,
  output logic              err_injected
);
  import pkt_crc_pkg::*;

  localparam int CRC_BEATS = CRC_W / DATA_W;
  localparam int BEAT_W    = $clog2(CRC_BEATS + 1);

  tx_state_t         st_q;
  logic              in_pkt_q;
  logic [CRC_W-1:0]  crc_sh_q;
  logic [BEAT_W-1:0] beats_q;

  logic              load, accept, window, start, upd, hit, is_short, load_pat;
  logic [31:0]       crc_next;
  logic [DATA_W-1:0] tx_word;

  assign load     = !out_valid || out_ready;
  assign in_ready = load && (st_q == ST_DATA);            // R8
  assign accept   = in_valid && in_ready;
  assign window   = in_sop || in_pkt_q;
  assign start    = accept && in_sop;
  assign upd      = accept && window;
  assign hit      = upd && force_err;                     // R5
  assign load_pat = !in_pkt_q && (st_q == ST_DATA) && !start;

  pkt_crc_engine #(.DATA_W(DATA_W)) u_crc (
    .clk(clk), .rst(rst), .start(start), .update(upd),
    .data(in_data), .crc_next(crc_next)
  );

  pkt_len_gate #(.MIN_WORDS(MIN_WORDS)) u_len (
    .clk(clk), .rst(rst), .start(start), .update(upd), .is_short(is_short)
  );

  pkt_err_inject #(.DATA_W(DATA_W)) u_inj (
    .clk(clk), .rst(rst), .load_en(load_pat), .force_val(force_val),
    .hit(hit), .start(start), .data_in(in_data), .data_out(tx_word),
    .sticky(err_injected)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_DATA;
      in_pkt_q   <= 1'b0;
      crc_sh_q   <= '0;
      beats_q    <= '0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_sop    <= 1'b0;
      out_eop    <= 1'b0;
      out_is_crc <= 1'b0;
      out_short  <= 1'b0;
    end else begin
      if (accept) in_pkt_q <= window && !in_eop;
      if (load) begin
        if (st_q == ST_APPEND) begin
          // R2: CRC words, high part first, end marker on the last
          out_valid  <= 1'b1;
          out_data   <= crc_sh_q[CRC_W-1 -: DATA_W];
          crc_sh_q   <= crc_sh_q << DATA_W;
          beats_q    <= beats_q - BEAT_W'(1);
          out_sop    <= 1'b0;
          out_eop    <= (beats_q == BEAT_W'(1));
          out_is_crc <= 1'b1;
          out_short  <= 1'b0;
          if (beats_q == BEAT_W'(1)) st_q <= ST_DATA;
        end else if (accept) begin
          out_valid  <= 1'b1;
          out_data   <= tx_word;
          out_sop    <= start;
          out_is_crc <= 1'b0;
          out_eop    <= 1'b0;
          out_short  <= 1'b0;
          if (window && in_eop) begin
            if (is_short) begin                           // R9
              out_eop   <= 1'b1;
              out_short <= 1'b1;
            end else begin
              crc_sh_q <= ~crc_next;                      // R3
              beats_q  <= BEAT_W'(CRC_BEATS);
              st_q     <= ST_APPEND;
            end
          end
        end else begin
          out_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_crc_tx_chk.sv
module pkt_crc_tx_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              out_is_crc,
  input logic              out_short,
  input logic              err_injected
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready && !err_injected));

  assert_crc_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_crc && !out_eop) |-> !in_ready);

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_is_crc) && $stable(out_short)));

  assert_short_marks_end_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_short) |-> (out_eop && !out_is_crc));

  assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(err_injected));
endmodule

bind pkt_crc_tx pkt_crc_tx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/pkt_crc_tx_tb.sv
module pkt_crc_tx_tb;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int MINW  = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_ready, in_sop = 0, in_eop = 0, force_err = 0;
  logic [DW-1:0] in_data = '0, force_val = '0, out_data;
  logic out_valid, out_ready = 1'b1, out_sop, out_eop, out_is_crc, out_short, err_injected;

  typedef struct packed {logic [DW-1:0] d; logic sop, eop, crc, sh;} beat_t;
  beat_t got_q[$], exp_q[$];
  int n_chk = 0, n_bad = 0;
  bit bp_en = 0;
  logic [7:0] lfsr = 8'hA5;
  logic stall_prev = 0;
  logic [DW-1:0] stall_data;

  always #(CLK_P/2) clk = ~clk;

  pkt_crc_tx #(.DATA_W(DW), .MIN_WORDS(MINW)) u_dut (.*);

  function automatic logic [31:0] ref_crc(input logic [DW-1:0] w[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (w[k])
      for (int b = DW - 1; b >= 0; b--)
        c = (c[31] ^ w[k][b]) ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
    return ~c;
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= bp_en ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      if (stall_prev) check("R10", "stalled data held", {63'd0, out_valid} << 16 | out_data,
                            {63'd0, 1'b1} << 16 | stall_data);
      stall_prev = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid && out_ready)
        got_q.push_back('{out_data, out_sop, out_eop, out_is_crc, out_short});
    end
  end

  task automatic put(logic [DW-1:0] d, logic s, logic e, logic f);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sop = s; in_eop = e; force_err = f;
    forever begin #1; if (in_ready) break; @(negedge clk); end
    @(posedge clk);
  endtask

  task automatic send_pkt(logic [DW-1:0] w[$], bit f[$], bit gapf, logic [DW-1:0] pat,
                          int chg_at, logic [DW-1:0] new_val);
    logic [31:0] c;
    bit sh;
    sh = (w.size() < MINW);
    foreach (w[i]) begin
      if (i == chg_at) force_val = new_val;
      if (gapf && i > 0) begin
        @(negedge clk); in_valid = 0; force_err = 1;
      end
      put(w[i], i == 0, i == w.size() - 1, f[i]);
    end
    @(negedge clk);
    in_valid = 0; force_err = 0; in_sop = 0; in_eop = 0;
    #1;
    if (!sh) check("R8", "ready low after end word", {63'd0, in_ready}, 64'd0);
    foreach (w[i])
      exp_q.push_back('{f[i] ? (w[i] ^ pat) : w[i], i == 0,
                        sh && (i == w.size() - 1), 1'b0, sh && (i == w.size() - 1)});
    if (!sh) begin
      c = ref_crc(w);
      for (int b = 32 / DW - 1; b >= 0; b--)
        exp_q.push_back('{c[b*DW +: DW], 1'b0, b == 0, 1'b1, 1'b0});
    end
  endtask

  task automatic drain_cmp(string req, bit exp_err);
    repeat (40) @(negedge clk);
    #3;
    check(req, "word count", got_q.size(), exp_q.size());
    while (got_q.size() > 0 && exp_q.size() > 0)
      check(req, "output word", got_q.pop_front(), exp_q.pop_front());
    got_q.delete(); exp_q.delete();
    check("R7", "sticky corruption flag", {63'd0, err_injected}, {63'd0, exp_err});
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check("R1", "out_valid", {63'd0, out_valid}, 64'd0);
    check("R1", "in_ready", {63'd0, in_ready}, 64'd1);
    check("R1", "err_injected", {63'd0, err_injected}, 64'd0);
  endtask

  task automatic t_basic();   // R2 R3
    send_pkt('{16'h1234, 16'hABCD, 16'h0F0F, 16'h8001}, '{0,0,0,0}, 0, '0, -1, '0);
    drain_cmp("R2", 0);
  endtask

  task automatic t_back2back();   // R3: preset per start word
    send_pkt('{16'hFFFF, 16'h0000, 16'h5A5A, 16'hC3C3, 16'h0001}, '{0,0,0,0,0}, 0, '0, -1, '0);
    send_pkt('{16'h0000, 16'h0000, 16'h0000}, '{0,0,0}, 0, '0, -1, '0);
    drain_cmp("R3", 0);
  endtask

  task automatic t_force();   // R4 R7
    force_val = 16'h00FF;
    repeat (2) @(negedge clk);
    send_pkt('{16'h1111, 16'h2222, 16'h3333, 16'h4444}, '{0,1,0,1}, 0, 16'h00FF, -1, '0);
    drain_cmp("R4", 1);
    repeat (5) @(negedge clk);
    #3 check("R7", "flag held while idle", {63'd0, err_injected}, 64'd1);
  endtask

  task automatic t_idle_force();   // R5 R7
    @(negedge clk); force_err = 1;
    repeat (3) @(negedge clk);
    force_err = 0;
    send_pkt('{16'h7777, 16'h8888, 16'h9999}, '{0,0,0}, 1, '0, -1, '0);
    drain_cmp("R5", 0);
  endtask

  task automatic t_pattern_lock();   // R6
    force_val = 16'hF000;
    repeat (2) @(negedge clk);
    send_pkt('{16'h0001, 16'h0002, 16'h0003, 16'h0004}, '{0,0,1,1}, 0, 16'hF000, 1, 16'h000F);
    drain_cmp("R6", 1);
    send_pkt('{16'h0101, 16'h0202, 16'h0303}, '{1,0,0}, 0, 16'h000F, -1, '0);
    drain_cmp("R6", 1);
  endtask

  task automatic t_short();   // R9, boundary at MINW
    send_pkt('{16'hBEEF}, '{0}, 0, '0, -1, '0);
    send_pkt('{16'hCAFE, 16'hF00D}, '{0,0}, 0, '0, -1, '0);
    send_pkt('{16'h0A0A, 16'h0B0B, 16'h0C0C}, '{0,0,0}, 0, '0, -1, '0);
    drain_cmp("R9", 0);
  endtask

  task automatic t_backpressure();   // R10 R8
    force_val = 16'h8000;
    bp_en = 1;
    repeat (2) @(negedge clk);
    send_pkt('{16'h1357, 16'h2468, 16'h9ABC, 16'hDEF0, 16'h1122}, '{0,0,1,0,0}, 0, 16'h8000, -1, '0);
    send_pkt('{16'h3344, 16'h5566, 16'h7788}, '{0,0,0}, 0, '0, -1, '0);
    send_pkt('{16'h99AA}, '{0}, 0, '0, -1, '0);
    drain_cmp("R10", 0);
    bp_en = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_back2back();
    t_force();
    t_idle_force();
    t_pattern_lock();
    t_short();
    t_backpressure();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule